// File: doc/BRIEF.md
# USB Packet Receive Deserializer

This block turns an already-sampled USB line stream into bytes for the link layer. One line level arrives per clock, qualified by a valid flag. Each level is written into a small elastic FIFO, which absorbs the rate difference between the recovered bit clock and the local clock. A decoder drains the FIFO and undoes NRZI coding. While idle it hunts for the start-of-packet preamble. Inside a packet it removes stuff bits and assembles bytes least-significant bit first.

Toward the link, `dir` rises once the preamble has been recognised and stays high for the whole packet. `nxt` pulses for one clock with each finished byte on `data`. Each byte is held back until the decoder knows whether another byte or the end-of-packet follows. Because of this, the last byte's `nxt` is immediately followed by the fall of `dir`.

A stuffing violation ends the packet. If it lands on a byte boundary it is the end-of-packet. Otherwise it is classified as a stuff error or a byte-alignment error. FIFO overrun and underrun are reported on their own lines. Any error aborts the packet, and the decoder returns to hunting.

Top module: `usb_rx_deser`

## Requirements
- R1: While reset is active and after its release, `dir`, `nxt` and all four error outputs are low until a packet is recognised.
- R2: A packet starts when, while hunting, at least SYNC_ZEROS (default 3) decoded zeros are followed by a decoded one. With fewer zeros before the one, `dir` stays low. The preamble bits never appear on `data`.
- R3: Decoding is NRZI. A sample equal to the previously consumed sample decodes as 1, a change decodes as 0, and the line is taken as level 1 before the first sample.
- R4: After six consecutive decoded ones, counting the final one of the preamble, the next bit is discarded when it is 0. It contributes no data.
- R5: Data bits are packed least-significant bit first. Each finished byte appears on `data` together with a one-clock `nxt` pulse, in arrival order.
- R6: `dir` rises one clock after the preamble's last bit is consumed, with `nxt` low in that clock. `nxt` is only ever high while `dir` is high. On a clean end, `dir` falls in the clock after the last byte's `nxt` pulse.
- R7: A decoded 1 in the stuff slot when exactly seven data bits of the current byte have been received is the end-of-packet. The packet ends without any error, and the partial byte is dropped. A packet with no bytes gives a `dir` pulse and no `nxt`.
- R8: A decoded 1 in the stuff slot at any other bit position, followed by a decoded 0, raises a one-clock `err_stuff`. The packet is aborted: `dir` falls at the same edge and the pending byte is not delivered.
- R9: The same violation followed by a decoded 1 raises a one-clock `err_align` instead and aborts the packet in the same way.
- R10: A sample that arrives while the FIFO (DEPTH entries, default 8) is full and nothing is read that clock is lost. It raises `err_ovr` and aborts a packet in progress. `err_ovr` takes precedence, so at most one error output is high in any clock.
- R11: After the preamble the decoder waits until the FIFO holds DEPTH/2 samples, then consumes one sample every RD_DIV clocks. A read slot that finds the FIFO empty raises `err_udr` and aborts the packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_valid | input | 1 | Qualifies `bit_in` for this clock |
| bit_in | input | 1 | Sampled line level |
| dir | output | 1 | High for the duration of a received packet |
| nxt | output | 1 | One-clock strobe: `data` carries a finished byte |
| data | output | 8 | Received byte |
| err_stuff | output | 1 | Pulse: stuff violation followed by a 0 |
| err_align | output | 1 | Pulse: end pattern not on a byte boundary |
| err_ovr | output | 1 | Pulse: elastic FIFO overrun |
| err_udr | output | 1 | Pulse: elastic FIFO underrun |

## Verification
The bench builds the block with DEPTH 8, SYNC_ZEROS 3 and RD_DIV 2. With RD_DIV 2 the decoder consumes one sample every second clock, so the bench sets the FIFO's fill direction by changing only the spacing of `bit_valid`. Samples every second clock hold the level steady for clean packets. Back-to-back samples fill the FIFO to overrun, and one sample every fourth clock drains it to underrun. The stuff and alignment cases are driven as raw decoded bit sequences. Their violation lands at a known bit position inside the first byte, and the bit after it selects which error is reported.

// File: rtl/usb_rx_pkg.sv
`timescale 1ns/1ps
package usb_rx_pkg;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_PRIME,
    ST_RUN,
    ST_CHK,
    ST_ENDP
  } rx_state_e;

  typedef struct packed {
    logic stuff;
    logic align;
    logic ovr;
    logic udr;
  } rx_err_t;

endpackage

// File: rtl/usb_rx_efifo.sv
`timescale 1ns/1ps
// Elastic bit FIFO between the sampled line and the decoder (DEPTH a power of two).
module usb_rx_efifo #(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_bit,
  input  logic          rd_en,
  output logic          rd_bit,
  output logic          empty,
  output logic          full,
  output logic [LW-1:0] level,
  output logic          ovr
);

  logic [DEPTH-1:0] mem_q;
  logic [AW-1:0]    wptr_q, wptr_n, rptr_q, rptr_n;
  logic [LW-1:0]    cnt_q, cnt_n;
  logic             wr_ok, rd_ok;

  assign empty  = (cnt_q == '0);
  assign full   = (cnt_q == LW'(DEPTH));
  assign level  = cnt_q;
  assign rd_bit = mem_q[rptr_q];
  assign wr_ok  = wr_en && (!full || rd_en);
  assign rd_ok  = rd_en && !empty;
  assign ovr    = wr_en && full && !rd_en;

  always_comb begin
    wptr_n = wptr_q;
    rptr_n = rptr_q;
    cnt_n  = cnt_q;
    if (wr_ok) wptr_n = wptr_q + AW'(1);
    if (rd_ok) rptr_n = rptr_q + AW'(1);
    if (wr_ok && !rd_ok)      cnt_n = cnt_q + LW'(1);
    else if (!wr_ok && rd_ok) cnt_n = cnt_q - LW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_n;
      rptr_q <= rptr_n;
      cnt_q  <= cnt_n;
    end
  end

  // storage needs no reset: it is only read while the count is non-zero
  always_ff @(posedge clk) begin
    if (wr_ok) mem_q[wptr_q] <= wr_bit;
  end

  a_r10_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rd_en) |=> full);

  a_r11_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !empty);

endmodule

// File: rtl/usb_rx_nrzi.sv
`timescale 1ns/1ps
// NRZI decode: an unchanged level is a one, a change is a zero.
module usb_rx_nrzi (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic lvl,
  output logic dbit
);

  logic prev_q, prev_n;

  assign dbit = (lvl == prev_q);

  always_comb begin
    prev_n = adv ? lvl : prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= prev_n;
  end

endmodule

// File: rtl/usb_rx_ctrl.sv
`timescale 1ns/1ps
// Preamble hunt, destuffing, byte packing, end detection and link framing.
module usb_rx_ctrl
  import usb_rx_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int RD_DIV     = 1,
  parameter int SYNC_ZEROS = 3,
  localparam int LW   = $clog2(DEPTH) + 1,
  localparam int HALF = DEPTH / 2,
  localparam int DW   = (RD_DIV > 1) ? $clog2(RD_DIV) : 1,
  localparam int ZW   = $clog2(SYNC_ZEROS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_empty,
  input  logic [LW-1:0] fifo_level,
  input  logic          fifo_ovr,
  input  logic          dbit,
  output logic          pop,
  output logic          dir,
  output logic          nxt,
  output logic [7:0]    data,
  output rx_err_t       err
);

  rx_state_e     state_q, state_n;
  logic [ZW-1:0] zcnt_q, zcnt_n;
  logic [2:0]    ones_q, ones_n, bitc_q, bitc_n;
  logic [7:0]    sh_q, sh_n, pend_q, pend_n, data_q, data_n;
  logic          pend_v_q, pend_v_n, dir_q, dir_n, nxt_q, nxt_n;
  logic [DW-1:0] divc_q, divc_n;
  rx_err_t       err_q, err_n;
  logic          tick, abort;

  assign tick = (divc_q == DW'(RD_DIV - 1));

  always_comb begin
    state_n  = state_q;
    zcnt_n   = zcnt_q;
    ones_n   = ones_q;
    bitc_n   = bitc_q;
    sh_n     = sh_q;
    pend_n   = pend_q;
    pend_v_n = pend_v_q;
    divc_n   = divc_q;
    dir_n    = dir_q;
    data_n   = data_q;
    nxt_n    = 1'b0;
    err_n    = '0;
    pop      = 1'b0;
    abort    = 1'b0;
    case (state_q)
      ST_HUNT: begin
        pop = !fifo_empty;
        if (pop) begin
          if (!dbit) begin
            if (zcnt_q != ZW'(SYNC_ZEROS)) zcnt_n = zcnt_q + ZW'(1);
          end else begin
            zcnt_n = '0;
            if (zcnt_q == ZW'(SYNC_ZEROS)) begin
              state_n  = ST_PRIME;
              dir_n    = 1'b1;
              ones_n   = 3'd1;
              bitc_n   = 3'd0;
              pend_v_n = 1'b0;
            end
          end
        end
      end
      ST_PRIME: begin
        if (fifo_level >= LW'(HALF)) begin
          state_n = ST_RUN;
          divc_n  = '0;
        end
      end
      ST_RUN, ST_CHK: begin
        divc_n = tick ? '0 : divc_q + DW'(1);
        if (tick) begin
          if (fifo_empty) begin
            err_n.udr = 1'b1;
            abort     = 1'b1;
          end else begin
            pop = 1'b1;
            if (state_q == ST_CHK) begin
              err_n.align = dbit;
              err_n.stuff = !dbit;
              abort       = 1'b1;
            end else if (ones_q == 3'd6) begin
              if (!dbit) begin
                ones_n = 3'd0;
              end else if (bitc_q == 3'd7) begin
                state_n  = ST_ENDP;
                pend_v_n = 1'b0;
                if (pend_v_q) begin
                  nxt_n  = 1'b1;
                  data_n = pend_q;
                end
              end else begin
                state_n = ST_CHK;
              end
            end else begin
              sh_n   = {dbit, sh_q[7:1]};
              ones_n = dbit ? ones_q + 3'd1 : 3'd0;
              bitc_n = bitc_q + 3'd1;
              if (bitc_q == 3'd7) begin
                if (pend_v_q) begin
                  nxt_n  = 1'b1;
                  data_n = pend_q;
                end
                pend_n   = {dbit, sh_q[7:1]};
                pend_v_n = 1'b1;
              end
            end
          end
        end
      end
      ST_ENDP: begin
        dir_n   = 1'b0;
        state_n = ST_HUNT;
        zcnt_n  = '0;
      end
      default: state_n = ST_HUNT;
    endcase
    if (fifo_ovr) begin
      err_n     = '0;
      err_n.ovr = 1'b1;
      if (state_q inside {ST_PRIME, ST_RUN, ST_CHK}) abort = 1'b1;
    end
    if (abort) begin
      state_n  = ST_HUNT;
      dir_n    = 1'b0;
      nxt_n    = 1'b0;
      zcnt_n   = '0;
      pend_v_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_HUNT;
      zcnt_q   <= '0;
      ones_q   <= '0;
      bitc_q   <= '0;
      sh_q     <= '0;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
      divc_q   <= '0;
      dir_q    <= 1'b0;
      nxt_q    <= 1'b0;
      data_q   <= '0;
      err_q    <= '0;
    end else begin
      state_q  <= state_n;
      zcnt_q   <= zcnt_n;
      ones_q   <= ones_n;
      bitc_q   <= bitc_n;
      sh_q     <= sh_n;
      pend_q   <= pend_n;
      pend_v_q <= pend_v_n;
      divc_q   <= divc_n;
      dir_q    <= dir_n;
      nxt_q    <= nxt_n;
      data_q   <= data_n;
      err_q    <= err_n;
    end
  end

  assign dir  = dir_q;
  assign nxt  = nxt_q;
  assign data = data_q;
  assign err  = err_q;

  a_r6_nxt_inside_dir: assert property (@(posedge clk) disable iff (!rst_n)
    nxt_q |-> dir_q);

  a_r6_no_nxt_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dir_q) |-> !nxt_q);

  a_r8_err_drops_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q.stuff || err_q.align || err_q.udr) |-> !dir_q);

  a_r10_single_err: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(err_q));

endmodule

// File: rtl/usb_rx_deser.sv
`timescale 1ns/1ps
module usb_rx_deser
  import usb_rx_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int RD_DIV     = 1,
  parameter int SYNC_ZEROS = 3,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_valid,
  input  logic       bit_in,
  output logic       dir,
  output logic       nxt,
  output logic [7:0] data,
  output logic       err_stuff,
  output logic       err_align,
  output logic       err_ovr,
  output logic       err_udr
);

  logic [1:0]    rsync_q;
  logic          rst_core_n;
  logic          pop, fifo_bit, fifo_empty, fifo_full, fifo_ovr, dbit;
  logic [LW-1:0] fifo_level;
  rx_err_t       err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  usb_rx_efifo #(.DEPTH(DEPTH)) u_fifo (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .wr_en  (bit_valid),
    .wr_bit (bit_in),
    .rd_en  (pop),
    .rd_bit (fifo_bit),
    .empty  (fifo_empty),
    .full   (fifo_full),
    .level  (fifo_level),
    .ovr    (fifo_ovr)
  );

  usb_rx_nrzi u_nrzi (
    .clk   (clk),
    .rst_n (rst_core_n),
    .adv   (pop),
    .lvl   (fifo_bit),
    .dbit  (dbit)
  );

  usb_rx_ctrl #(.DEPTH(DEPTH), .RD_DIV(RD_DIV), .SYNC_ZEROS(SYNC_ZEROS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .fifo_empty (fifo_empty),
    .fifo_level (fifo_level),
    .fifo_ovr   (fifo_ovr),
    .dbit       (dbit),
    .pop        (pop),
    .dir        (dir),
    .nxt        (nxt),
    .data       (data),
    .err        (err)
  );

  assign err_stuff = err.stuff;
  assign err_align = err.align;
  assign err_ovr   = err.ovr;
  assign err_udr   = err.udr;

  a_r10_ovr_needs_full: assert property (@(posedge clk) disable iff (!rst_core_n)
    fifo_ovr |-> fifo_full);

endmodule

// File: tb/test_usb_rx_deser.sv
`timescale 1ns/1ps
module test_usb_rx_deser;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_valid, bit_in;
  logic       dir, nxt, err_stuff, err_align, err_ovr, err_udr;
  logic [7:0] data;

  always #2.5 clk = ~clk;

  usb_rx_deser #(.DEPTH(8), .RD_DIV(2), .SYNC_ZEROS(3)) i_usb_rx_deser (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .dir(dir), .nxt(nxt), .data(data),
    .err_stuff(err_stuff), .err_align(err_align), .err_ovr(err_ovr), .err_udr(err_udr)
  );

  int n_chk = 0;
  int n_bad = 0;

  // link-side monitor, sampled at the falling edge
  int         nb, rises, falls;
  logic [7:0] rx [16];
  bit         s_stuff, s_align, s_ovr, s_udr, nxt_bad, end_ok, p_dir, p_nxt;

  always @(negedge clk) begin
    if (rst_n) begin
      if (nxt) begin
        if (nb < 16) rx[nb] = data;
        nb++;
        if (!dir) nxt_bad = 1;
      end
      if (err_stuff) s_stuff = 1;
      if (err_align) s_align = 1;
      if (err_ovr)   s_ovr   = 1;
      if (err_udr)   s_udr   = 1;
      if (dir && !p_dir) begin
        rises++;
        if (nxt) nxt_bad = 1;
      end
      if (!dir && p_dir) begin
        falls++;
        end_ok = p_nxt;
      end
      p_dir = dir;
      p_nxt = nxt;
    end
  end

  task automatic mon_clear();
    nb = 0; rises = 0; falls = 0;
    s_stuff = 0; s_align = 0; s_ovr = 0; s_udr = 0;
    nxt_bad = 0; end_ok = 0;
  endtask

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // line encoder
  bit         lvl = 1'b1;
  int         gap = 1;
  int         ones = 0;
  logic [7:0] pay [8];

  task automatic drv(bit l);
    @(negedge clk);
    bit_valid = 1'b1;
    bit_in    = l;
    if (gap > 0) begin
      @(negedge clk);
      bit_valid = 1'b0;
      repeat (gap - 1) @(negedge clk);
    end
  endtask

  task automatic enc(bit b);
    if (!b) lvl = ~lvl;
    drv(lvl);
  endtask

  task automatic send_sync();
    for (int i = 0; i < 7; i++) enc(1'b0);
    enc(1'b1);
    ones = 1;
  endtask

  task automatic send_byte(logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      enc(v[i]);
      ones = v[i] ? ones + 1 : 0;
      if (ones == 6) begin
        enc(1'b0);
        ones = 0;
      end
    end
  endtask

  task automatic send_eop_tail();
    enc(1'b0);
    for (int i = 0; i < 7; i++) enc(1'b1);
    for (int i = 0; i < 6; i++) enc(1'b1);
    @(negedge clk);
    bit_valid = 1'b0;
  endtask

  task automatic run_packet(string tag, int n);
    mon_clear();
    gap = 1;
    send_sync();
    for (int i = 0; i < n; i++) send_byte(pay[i]);
    send_eop_tail();
    repeat (40) @(negedge clk);
    chk("R5", {tag, " byte count"}, nb, n);
    for (int i = 0; i < n; i++) chk("R5", {tag, " byte value"}, int'(rx[i]), int'(pay[i]));
    chk("R2", {tag, " dir rises once"}, rises, 1);
    chk("R6", {tag, " dir falls once"}, falls, 1);
    if (n > 0) chk("R6", {tag, " dir falls right after last nxt"}, int'(end_ok), 1);
    chk("R6", {tag, " nxt outside dir"}, int'(nxt_bad), 0);
    chk("R7", {tag, " clean end, no error"}, int'(s_stuff | s_align | s_ovr | s_udr), 0);
  endtask

  task automatic t_reset();
    bit_valid = 1'b0;
    bit_in    = 1'b1;
    rst_n     = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1", "dir in reset", int'(dir), 0);
    chk("R1", "nxt in reset", int'(nxt), 0);
    chk("R1", "errors in reset", int'({err_stuff, err_align, err_ovr, err_udr}), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1", "dir after reset", int'(dir), 0);
    chk("R1", "errors after reset", int'({err_stuff, err_align, err_ovr, err_udr}), 0);
    p_dir = 0;
    p_nxt = 0;
  endtask

  task automatic t_single();
    pay[0] = 8'hA5;
    run_packet("R3 single byte", 1);
  endtask

  task automatic t_mixed();
    pay[0] = 8'h2D; pay[1] = 8'h00; pay[2] = 8'h10;
    run_packet("R5 three bytes", 3);
  endtask

  task automatic t_stuffing();
    pay[0] = 8'hFF; pay[1] = 8'hFF; pay[2] = 8'h7E; pay[3] = 8'hFC;
    run_packet("R4 stuffed ones", 4);
  endtask

  task automatic t_empty();
    mon_clear();
    gap = 1;
    send_sync();
    send_eop_tail();
    repeat (40) @(negedge clk);
    chk("R7", "empty packet nxt count", nb, 0);
    chk("R7", "empty packet dir pulse", rises + falls, 2);
    chk("R7", "empty packet no error", int'(s_stuff | s_align | s_ovr | s_udr), 0);
  endtask

  task automatic t_short_sync();
    mon_clear();
    gap = 1;
    enc(1'b0); enc(1'b0); enc(1'b1);
    for (int i = 0; i < 8; i++) enc(1'b1);
    @(negedge clk);
    bit_valid = 1'b0;
    repeat (30) @(negedge clk);
    chk("R2", "two zeros then one: dir stays low", rises, 0);
  endtask

  task automatic t_stuff_err();
    mon_clear();
    gap = 1;
    send_sync();
    for (int i = 0; i < 6; i++) enc(1'b1);
    enc(1'b0);
    for (int i = 0; i < 8; i++) enc(1'b1);
    @(negedge clk);
    bit_valid = 1'b0;
    repeat (30) @(negedge clk);
    chk("R8", "stuff error raised", int'(s_stuff), 1);
    chk("R8", "no align error", int'(s_align), 0);
    chk("R8", "no data delivered", nb, 0);
    chk("R8", "dir dropped", falls, 1);
  endtask

  task automatic t_align_err();
    mon_clear();
    gap = 1;
    send_sync();
    for (int i = 0; i < 7; i++) enc(1'b1);
    for (int i = 0; i < 8; i++) enc(1'b1);
    @(negedge clk);
    bit_valid = 1'b0;
    repeat (30) @(negedge clk);
    chk("R9", "align error raised", int'(s_align), 1);
    chk("R9", "no stuff error", int'(s_stuff), 0);
    chk("R9", "no data delivered", nb, 0);
    chk("R9", "dir dropped", falls, 1);
  endtask

  task automatic t_rate(int g, string req);
    mon_clear();
    gap = g;
    send_sync();
    for (int i = 0; i < 4; i++) send_byte(8'hFF);
    send_eop_tail();
    repeat (60) @(negedge clk);
    gap = 1;
    if (req == "R10") begin
      chk("R10", "overrun raised", int'(s_ovr), 1);
      chk("R10", "no underrun", int'(s_udr), 0);
    end else begin
      chk("R11", "underrun raised", int'(s_udr), 1);
      chk("R11", "no overrun", int'(s_ovr), 0);
    end
    chk(req, "packet aborted, dir fell", falls, 1);
    chk(req, "no end-of-packet handshake", int'(end_ok), 0);
  endtask

  task automatic t_recover();
    pay[0] = 8'h3C; pay[1] = 8'hC3;
    run_packet("R10 recovery", 2);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_mixed();
    t_stuffing();
    t_empty();
    t_short_sync();
    t_stuff_err();
    t_align_err();
    t_recover();
    t_rate(3, "R11");
    t_rate(0, "R10");
    t_recover();
    summary();
    $finish;
  end

endmodule